// File: doc/BRIEF.md
# Per-Port Interrupt Status Aggregator

This block gathers interrupt events from several serial-link receive ports and presents them through a single register window. Each port owns a seven-bit sticky status word. A set bit records that one of the following happened since the bit was last cleared: a lock change, a port-valid change, a link parity error, a camera-serial receiver error, a receive buffer overflow, a change in lines per frame, or a change in line length. A port-select register decides which port's word a summary read returns. The same register decides which port a clearing read acts on.

The summary register is read-only, and reading it changes nothing. A bit is cleared only as a side effect of reading the detail register that carries the cause, and only for the selected port. Every port drives its own interrupt line, which is high while any of its status bits is set. A single global line is the OR of all the port lines. Event detection and the bus protocol stay outside the block. The block sees only qualified read and write strobes together with an address.

Top module: `irq_status_hub`

## Requirements
- R1: After synchronous reset, every status bit is 0, the port select is 0, and `port_irq_o` and `any_irq_o` are 0.
- R2: An event pulse on `evt_i[p*7+b]` sets status bit b of port p on the next clock edge. The bit stays set until it is cleared. Bit map: 0 lock change, 1 port-valid change, 2 link parity error, 3 camera-serial receiver error, 4 buffer overflow, 5 line-count change, 6 line-length change.
- R3: Bit 7 of every read result is 0.
- R4: A read of the summary address (default 0x48) returns `{1'b0, status[sel]}` on `rd_data_o` in the cycle after `rd_en_i`, with `rd_valid_o` high. A read of the summary address, or of any address that is not a clearing address, leaves all status bits unchanged. A read of an unmapped address returns 0.
- R5: A read of the first port status address (default 0x4D) clears bits 0, 1 and 2 of the selected port.
- R6: A read of the receiver error address 0x7A clears bit 3 of the selected port.
- R7: A read of the second port status address (default 0x4E) clears bits 4, 5 and 6 of the selected port.
- R8: A clearing read leaves every non-selected port unchanged, and it leaves the bits of the selected port that belong to other detail registers unchanged.
- R9: If an event for a bit arrives in the same cycle as a read that clears that bit, the bit is set after that edge.
- R10: `port_irq_o[p]` is high exactly when port p has any status bit set. `any_irq_o` is the OR of all `port_irq_o` bits.
- R11: A write to address 0x4C with a value below NUM_PORTS loads the port select. A write with a larger value is ignored. A read of 0x4C returns the select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_PORTS*7 | One-cycle event pulses, 7 per port |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, valid the cycle after the strobe |
| rd_valid_o | output | 1 | Marks rd_data_o valid |
| port_irq_o | output | NUM_PORTS | Per-port interrupt, OR of its status bits |
| any_irq_o | output | 1 | OR of all port interrupts |

## Verification
The bench fills two ports at once and then clears them through the other port. A design that decodes the port select wrongly would wipe the wrong port's bits. It then fires an event in the same cycle as the read that clears that bit; a design that gives the clear priority would lose the event. Each clearing address is tested against a full status word, so masks that reach into a neighbouring detail register's bits show up as wrong summary values. Select writes of 4 and 255 must leave the current port in place. Repeated summary reads and reads of unmapped addresses must return the same status without clearing anything.

// File: rtl/irq_hub_pkg.sv
// Package: shared widths and clear-mask constants for the interrupt hub.
// Assumes every port has exactly seven event bits.
package irq_hub_pkg;
    localparam int EVT_W = 7;
    typedef logic [EVT_W-1:0] evt_vec_t;
    // Bits each detail-register read clears
    localparam evt_vec_t CLR_STS1 = 7'b000_0111;
    localparam evt_vec_t CLR_CSI  = 7'b000_1000;
    localparam evt_vec_t CLR_STS2 = 7'b111_0000;
endpackage

// File: rtl/irq_sel_decode.sv
// Port-select register and clear decoder.
// Holds the selected port index, ignores out-of-range select writes, and turns
// a read of a detail register into a clear mask plus a one-hot port enable.
// Assumes NUM_PORTS is at most 255.
module irq_sel_decode
    import irq_hub_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_SEL  = 8'h4C,
    parameter logic [ADDR_W-1:0] ADDR_CSI  = 8'h7A,
    parameter logic [ADDR_W-1:0] ADDR_STS1 = 8'h4D,
    parameter logic [ADDR_W-1:0] ADDR_STS2 = 8'h4E,
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [IDX_W-1:0]  sel_o,
    output evt_vec_t          clr_mask_o,
    output logic [NUM_PORTS-1:0] clr_port_o
);
    localparam logic [7:0] PORT_LIM = 8'(NUM_PORTS);

    logic [IDX_W-1:0] sel_q;
    logic             sel_wr;

    assign sel_wr = wr_en_i && (addr_i == ADDR_SEL) && (wr_data_i < PORT_LIM);

    // Select register: loads only in-range indices
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (sel_wr)
            sel_q <= wr_data_i[IDX_W-1:0];
    end

    // Clear mask chosen by the detail register being read
    always_comb begin
        clr_mask_o = '0;
        if (rd_en_i) begin
            if (addr_i == ADDR_STS1) clr_mask_o = CLR_STS1;
            if (addr_i == ADDR_CSI)  clr_mask_o = CLR_CSI;
            if (addr_i == ADDR_STS2) clr_mask_o = CLR_STS2;
        end
    end

    // One-hot port enable for the clear
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        assign clr_port_o[i] = (sel_q == IDX_W'(i)) && (|clr_mask_o);
    end

    assign sel_o = sel_q;

    // A clear reaches at most one port (R8)
    assert_clear_one_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_port_o));
    // Out-of-range select writes leave the select as it was (R11)
    assert_bad_sel_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_SEL && wr_data_i >= PORT_LIM) |=> $stable(sel_q));
endmodule

// File: rtl/irq_port_latch.sv
// Sticky status word for one receive port.
// An event sets its bit and a clear drops it; an event in the same cycle as
// its clear wins. Assumes the clear input is already gated for this port.
module irq_port_latch
    import irq_hub_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t evt_i,
    input  evt_vec_t clr_i,
    output evt_vec_t stat_o,
    output logic     irq_o
);
    evt_vec_t stat_q;

    // Status update: clear first, then let new events set bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_i) | evt_i;
    end

    assign stat_o = stat_q;
    assign irq_o  = |stat_q;

    for (genvar b = 0; b < EVT_W; b++) begin : g_chk
        // An event always leaves its bit set, clearing read or not (R9)
        assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[b] |=> stat_q[b]);
        // A set bit stays until a clear arrives (R2)
        assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[b] && !clr_i[b]) |=> stat_q[b]);
        // A clear without a fresh event drops the bit (R5)
        assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !evt_i[b]) |=> !stat_q[b]);
        // No bit sets without an event (R2)
        assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!stat_q[b] && !evt_i[b]) |=> !stat_q[b]);
    end
endmodule

// File: rtl/irq_status_hub.sv
// Top of the interrupt status aggregator.
// Instantiates one sticky status word per port, the select and clear decoder,
// and a registered read port. Assumes the strobes are single-cycle and already
// qualified by the bus logic.
module irq_status_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_SUM  = 8'h48,
    parameter logic [ADDR_W-1:0] ADDR_SEL  = 8'h4C,
    parameter logic [ADDR_W-1:0] ADDR_CSI  = 8'h7A,
    parameter logic [ADDR_W-1:0] ADDR_STS1 = 8'h4D,
    parameter logic [ADDR_W-1:0] ADDR_STS2 = 8'h4E
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS*EVT_W-1:0] evt_i,
    input  logic                       rd_en_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [7:0]                 wr_data_i,
    output logic [7:0]                 rd_data_o,
    output logic                       rd_valid_o,
    output logic [NUM_PORTS-1:0]       port_irq_o,
    output logic                       any_irq_o
);
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [IDX_W-1:0]     sel;
    evt_vec_t             clr_mask;
    logic [NUM_PORTS-1:0] clr_port;
    evt_vec_t             stat [NUM_PORTS];

    irq_sel_decode #(
        .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .ADDR_SEL(ADDR_SEL),
        .ADDR_CSI(ADDR_CSI), .ADDR_STS1(ADDR_STS1), .ADDR_STS2(ADDR_STS2)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wr_data_i(wr_data_i), .sel_o(sel),
        .clr_mask_o(clr_mask), .clr_port_o(clr_port)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        evt_vec_t clr_p;
        assign clr_p = clr_port[p] ? clr_mask : '0;
        irq_port_latch u_latch (
            .clk(clk), .rst_n(rst_n),
            .evt_i(evt_i[p*EVT_W +: EVT_W]), .clr_i(clr_p),
            .stat_o(stat[p]), .irq_o(port_irq_o[p])
        );
    end

    assign any_irq_o = |port_irq_o;

    // Registered read port: summary of the selected port, or the select itself
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) begin
                if (addr_i == ADDR_SUM)
                    rd_data_o <= {1'b0, stat[sel]};
                else if (addr_i == ADDR_SEL)
                    rd_data_o <= 8'(sel);
                else
                    rd_data_o <= '0;
            end
        end
    end

    // Reserved bit never reads as 1 (R3)
    assert_bit7_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !rd_data_o[7]);
    // Global interrupt only rises after some event (R10)
    assert_any_rise_needs_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_irq_o) |-> $past(|evt_i));
    // Summary reads have no side effect (R4)
    assert_summary_read_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_SUM && evt_i == '0) |=> $stable(port_irq_o));
endmodule

// File: tb/sim_irq_status_hub.sv
`timescale 1ns/1ps
// Scoreboard bench: the step task drives one cycle and queues the expected
// read data; the monitor pops and compares when rd_valid_o is high.
module sim_irq_status_hub;
    localparam int NP = 4;
    localparam int EW = 7;
    localparam logic [7:0] A_SUM = 8'h48, A_SEL = 8'h4C, A_CSI = 8'h7A,
                           A_S1 = 8'h4D, A_S2 = 8'h4E;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic [NP*EW-1:0] evt;
    logic rd_en, wr_en;
    logic [7:0] addr, wr_data, rd_data;
    logic rd_valid, any_irq;
    logic [NP-1:0] port_irq;

    irq_status_hub #(.NUM_PORTS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wr_data_i(wr_data), .rd_data_o(rd_data),
        .rd_valid_o(rd_valid), .port_irq_o(port_irq), .any_irq_o(any_irq)
    );

    int n_cmp = 0, n_bad = 0;
    logic [6:0] mdl [NP];
    int msel = 0;
    logic [7:0] q_dat[$];
    string q_tag[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle; queue the expected read; update the model at the edge
    task automatic step(logic [NP*EW-1:0] ev, logic rd, logic wr,
                        logic [7:0] a, logic [7:0] wd, string tag);
        logic [6:0] m;
        @(negedge clk);
        evt = ev; rd_en = rd; wr_en = wr; addr = a; wr_data = wd;
        if (rd) begin
            if (a == A_SUM)      q_dat.push_back({1'b0, mdl[msel]});
            else if (a == A_SEL) q_dat.push_back(8'(msel));
            else                 q_dat.push_back(8'h00);
            q_tag.push_back(tag);
        end
        m = !rd ? 7'h00 : (a == A_S1) ? 7'h07 : (a == A_CSI) ? 7'h08 :
            (a == A_S2) ? 7'h70 : 7'h00;
        @(posedge clk);
        for (int p = 0; p < NP; p++)
            mdl[p] = (mdl[p] & ~((p == msel) ? m : 7'h00)) | ev[p*EW +: EW];
        if (wr && a == A_SEL && wd < NP) msel = int'(wd);
    endtask

    task automatic rd(logic [7:0] a, string tag); step('0, 1'b1, 1'b0, a, 8'h00, tag); endtask
    task automatic wsel(logic [7:0] v);            step('0, 1'b0, 1'b1, A_SEL, v, ""); endtask
    task automatic ev(logic [NP*EW-1:0] e);        step(e, 1'b0, 1'b0, 8'h00, 8'h00, ""); endtask

    // Monitor: read data against the queue, interrupt lines against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (rd_valid) begin
                if (q_dat.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R4 unexpected read actual=%0h expected=none", rd_data);
                end else begin
                    check(q_tag.pop_front(), rd_data, q_dat.pop_front());
                    check("R3 bit7", rd_data[7], 1'b0);
                end
            end
            begin
                logic any_m;
                any_m = 1'b0;
                for (int p = 0; p < NP; p++) begin
                    check("R10 port irq", port_irq[p], |mdl[p]);
                    any_m |= |mdl[p];
                end
                check("R10 any irq", any_irq, any_m);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog all-requirements actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) mdl[p] = '0;
        rst_n = 1'b0; evt = '0; rd_en = 0; wr_en = 0; addr = '0; wr_data = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        check("R1 reset irq", {port_irq, any_irq}, '0);
        rd(A_SUM, "R1 reset summary");
        rd(A_SEL, "R1 reset select");
        // R2 latch, R4 repeated reads have no side effect
        ev(28'h1);
        rd(A_SUM, "R2 lock bit");
        rd(A_SUM, "R4 reread");
        rd(8'h10, "R4 unmapped read");
        rd(A_SUM, "R4 after unmapped");
        // Port 2 fully set, clear it register by register
        ev(28'h7F << 14);
        wsel(8'd2);
        rd(A_SEL, "R11 select 2");
        rd(A_SUM, "R2 all bits");
        rd(A_S1, "R5 clear read");
        rd(A_SUM, "R5 bits 0-2 cleared");
        rd(A_CSI, "R6 clear read");
        rd(A_SUM, "R6 bit 3 cleared");
        rd(A_S2, "R7 clear read");
        rd(A_SUM, "R7 bits 4-6 cleared");
        // R8 other ports untouched
        ev((28'h7F << 7) | (28'h7F << 21));
        wsel(8'd3);
        rd(A_S1, "R8 clr"); rd(A_CSI, "R8 clr"); rd(A_S2, "R8 clr");
        rd(A_SUM, "R8 selected port empty");
        wsel(8'd0);
        rd(A_SUM, "R8 port0 kept");
        wsel(8'd1);
        rd(A_SUM, "R8 port1 kept");
        // R9 event in the clear cycle
        step((28'h11 << 7), 1'b1, 1'b0, A_S1, 8'h00, "R9 clr+evt");
        rd(A_SUM, "R9 bit0 kept");
        step((28'h20 << 7), 1'b1, 1'b0, A_S2, 8'h00, "R9 clr+evt");
        rd(A_SUM, "R9 bit5 kept");
        // R11 out-of-range select writes
        wsel(8'd4);
        rd(A_SEL, "R11 sel 4 ignored");
        wsel(8'd255);
        rd(A_SEL, "R11 sel 255 ignored");
        wsel(8'd3);
        rd(A_SEL, "R11 sel 3");
        // Drain everything for R10
        for (int p = 0; p < NP; p++) begin
            wsel(8'(p));
            rd(A_S1, "R5 drain"); rd(A_CSI, "R6 drain"); rd(A_S2, "R7 drain");
        end
        rd(A_SUM, "R10 drained");
        ev('0); ev('0);
        check("R10 all quiet", {port_irq, any_irq}, '0);
        check("R4 queue empty", q_dat.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule